// File: doc/BRIEF.md
# Clocked Pulse-Width Glitch Filter

This block cleans an edge-sensitive digital input before it drives an edge counter. When an edge is noisy it can be seen as several edges, and each one would be counted. The filter stops that. The raw input first passes through a two-flop synchronizer. A prescaler then divides the system clock into a periodic filter strobe. The synchronized level is sampled once per strobe, and the output takes a new level only when two strobe samples in a row agree on it.

The result is stated in filter periods. P is the number of system clocks between strobes, and a two-bit select picks it from four fixed divide values. With an 80 MHz clock, the defaults give filter intervals of 5 us, 1 us, 500 ns and 100 ns. The guarantees are:
- A level held for 2P clocks or longer always reaches the output.
- A level held for P clocks or fewer never does.
- Widths between P and 2P may or may not pass, depending on where the strobe falls.

The select is a static setting, and it must be held steady while the filter is in use.

Top module: `pulse_glitch_filter`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, the output is low, even if the input is high.
- R2: A high pulse on a settled low input passes if it lasts 2P system clocks or longer. It gives exactly one rising and one falling output edge.
- R3: A high pulse on a settled low input is blocked if it lasts P system clocks or fewer. The output shows no edge.
- R4: Low pulses on a settled high input follow the same rules. A width of 2P or more gives one falling and one rising edge, and a width of P or fewer gives no edge.
- R5: The select picks P from the four divide parameters: 0 picks the longest interval (default 400), 1 the next (80), 2 the next (40), and 3 the shortest (8).
- R6: When the input changes to a new level and then holds it, the output shows that level no later than 2P+2 rising clock edges after the change.
- R7: The output never changes on two consecutive clock cycles. It changes only on the cycle after a filter strobe, and strobes are never adjacent.
- R8: An input that toggles on every clock and then settles high gives exactly one rising output edge and no falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 2 | Filter interval select, static while in use |
| raw_i | input | 1 | Unfiltered asynchronous input |
| filt_o | output | 1 | Filtered output |

## Verification
The risky coincidence is between the strobe and an input edge:
- A pulse edge can land on the same cycle as a strobe, or just before or after it.
- That decides whether a pulse of exactly P or 2P clocks is sampled once or twice.

The bench drives each pulse width after a stepped idle gap, so the pulse moves through every strobe phase. It judges only the widths that have a guaranteed outcome, by counting output edges. A second coincidence is a bouncing input whose toggles line up with the strobe spacing. The bench checks that this still gives a single output edge.

// File: rtl/pgf_pkg.sv
package pgf_pkg;

    localparam int unsigned NUM_SEL = 4;

    typedef struct packed {
        logic samp;
        logic out;
    } qual_state_t;

    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/pgf_sync.sv
module pgf_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pgf_prescaler.sv
module pgf_prescaler #(
    parameter int unsigned DIV0 = 400,
    parameter int unsigned DIV1 = 80,
    parameter int unsigned DIV2 = 40,
    parameter int unsigned DIV3 = 8
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] sel_i,
    output logic       tick_o
);
    import pgf_pkg::*;

    localparam int unsigned MAXDIV = max_of4(DIV0, DIV1, DIV2, DIV3);
    localparam int unsigned CNT_W  = (MAXDIV > 2) ? $clog2(MAXDIV) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } pre_state_t;

    pre_state_t       st_d, st_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        unique case (sel_i)
            2'd0:    lim = CNT_W'(DIV0 - 1);
            2'd1:    lim = CNT_W'(DIV1 - 1);
            2'd2:    lim = CNT_W'(DIV2 - 1);
            default: lim = CNT_W'(DIV3 - 1);
        endcase
        st_d = st_q;
        if (st_q.cnt >= lim) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o); // R7

endmodule

// File: rtl/pgf_qualifier.sv
module pgf_qualifier (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic lvl_i,
    output logic out_o
);
    import pgf_pkg::*;

    qual_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            st_d.samp = lvl_i;
            if ((lvl_i == st_q.samp) && (lvl_i != st_q.out)) begin
                st_d.out = lvl_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign out_o = st_q.out;

    AST_CHANGE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(out_o) |-> $past(tick_i)); // R7

    AST_TWO_SAMPLES_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(out_o) |-> ($past(lvl_i) == out_o) && ($past(st_q.samp) == out_o)); // R2

endmodule

// File: rtl/pulse_glitch_filter.sv
module pulse_glitch_filter #(
    parameter int unsigned DIV0        = 400,
    parameter int unsigned DIV1        = 80,
    parameter int unsigned DIV2        = 40,
    parameter int unsigned DIV3        = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] sel_i,
    input  logic       raw_i,
    output logic       filt_o
);
    logic sync_lvl;
    logic tick;

    pgf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (raw_i),
        .q_o    (sync_lvl)
    );

    pgf_prescaler #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sel_i  (sel_i),
        .tick_o (tick)
    );

    pgf_qualifier u_qual (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick),
        .lvl_i  (sync_lvl),
        .out_o  (filt_o)
    );

    always @(posedge clk_i) begin
        if (!rst_ni) begin
            AST_RESET_LOW: assert (!filt_o); // R1
        end
    end

endmodule

// File: tb/pulse_glitch_filter_tb.sv
module pulse_glitch_filter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int D0 = 5, D1 = 4, D2 = 3, D3 = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       raw = 1'b0;
    logic       filt;

    int n_checks = 0;
    int n_errors = 0;
    int rises = 0, falls = 0;
    int adjacent = 0;
    int cyc = 0, last_change = -10;
    logic prev_filt = 1'b0;
    bit done = 0;

    pulse_glitch_filter #(.DIV0(D0), .DIV1(D1), .DIV2(D2), .DIV3(D3)) u_dut (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .sel_i  (sel),
        .raw_i  (raw),
        .filt_o (filt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && filt !== prev_filt) begin
            if (filt) rises <= rises + 1;
            else      falls <= falls + 1;
            if (cyc - last_change < 2) adjacent <= adjacent + 1;
            last_change <= cyc;
        end
        prev_filt <= filt;
    end

    function automatic int per(input int s);
        case (s)
            0: return D0;
            1: return D1;
            2: return D2;
            default: return D3;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic settle(input logic lvl, input int p);
        raw = lvl;
        repeat (4*p + 8) @(negedge clk);
        rises = 0;
        falls = 0;
    endtask

    task automatic pulse_test(input int s, input logic base, input int w, input int ph);
        int p;
        int e;
        p = per(s);
        @(negedge clk);
        sel = s[1:0];
        settle(base, p);
        repeat (ph) @(negedge clk);
        raw = ~base;
        repeat (w) @(negedge clk);
        raw = base;
        repeat (2*p + 6) @(negedge clk);
        e = (w >= 2*p) ? 1 : 0;
        if (base == 1'b0) begin
            if (e == 1) begin
                check("R2 R5", rises, 1, $sformatf("rises sel=%0d w=%0d ph=%0d", s, w, ph));
                check("R2", falls, 1, $sformatf("falls sel=%0d w=%0d ph=%0d", s, w, ph));
            end else begin
                check("R3 R5", rises, 0, $sformatf("rises sel=%0d w=%0d ph=%0d", s, w, ph));
                check("R3", falls, 0, $sformatf("falls sel=%0d w=%0d ph=%0d", s, w, ph));
            end
        end else begin
            check("R4", falls, e, $sformatf("falls sel=%0d w=%0d ph=%0d", s, w, ph));
            check("R4", rises, e, $sformatf("rises sel=%0d w=%0d ph=%0d", s, w, ph));
        end
    endtask

    initial begin
        raw = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", int'(filt), 0, "output during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(filt), 0, "output first cycle after reset");

        for (int s = 0; s < 4; s++) begin
            for (int w = 1; w <= 2*per(s) + 1; w++) begin
                if (w > per(s) && w < 2*per(s)) continue;
                for (int ph = 0; ph < per(s); ph++) begin
                    pulse_test(s, 1'b0, w, ph);
                    pulse_test(s, 1'b1, w, ph);
                end
            end
        end

        for (int s = 0; s < 4; s++) begin
            for (int ph = 0; ph < per(s); ph++) begin
                @(negedge clk);
                sel = s[1:0];
                settle(1'b0, per(s));
                repeat (ph) @(negedge clk);
                raw = 1'b1;
                repeat (2*per(s) + 2) @(posedge clk);
                @(negedge clk);
                check("R6", int'(filt), 1, $sformatf("latency rise sel=%0d ph=%0d", s, ph));
                raw = 1'b0;
                repeat (2*per(s) + 2) @(posedge clk);
                @(negedge clk);
                check("R6", int'(filt), 0, $sformatf("latency fall sel=%0d ph=%0d", s, ph));
            end
        end

        for (int s = 0; s < 4; s++) begin
            for (int n = 5; n < 17; n++) begin
                @(negedge clk);
                sel = s[1:0];
                settle(1'b0, per(s));
                for (int k = 0; k < n; k++) begin
                    raw = ~raw;
                    @(negedge clk);
                end
                raw = 1'b1;
                repeat (2*per(s) + 6) @(negedge clk);
                check("R8", rises, 1, $sformatf("bounce rises sel=%0d n=%0d", s, n));
                check("R8", falls, 0, $sformatf("bounce falls sel=%0d n=%0d", s, n));
            end
        end

        check("R7", adjacent, 0, "output changes on adjacent cycles");
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule